// File: doc/BRIEF.md
# Tagged Stream FIFO

This block is a one-way, single-clock FIFO channel that moves words from one producer to one consumer. Every word carries a one-bit tag next to its data bits. The tag tells a control word apart from an ordinary data word. The tag goes into storage with its data and comes out with it.

The producer sees a `full` flag and the consumer sees an `exists` flag. The attached masters use these flags to choose between two behaviours:

- A blocking master waits on the flag.
- A non-blocking master strobes regardless and accepts the outcome. The word is dropped on a full write, and the read is ignored when the FIFO is empty.

The read side is first-word-fall-through: the oldest word and its tag are on the outputs whenever `exists` is high. A read strobe consumes that word. The depth and data width are parameters, with defaults of 16 words and 32 bits.

Top module: `tagged_stream_fifo`

## Requirements
- R1: A synchronous active-high reset empties the FIFO and drives `exists` and `full` low on the cycle after the reset edge.
- R2: A write strobe with `full` low stores the word. `exists` is high on the cycle after that write edge.
- R3: While `exists` is high, `rd_data` and `rd_tag` show the oldest stored word and its tag, without a read strobe. Words leave in the order they were written.
- R4: `full` goes high on the cycle after the write that brings occupancy to DEPTH. It stays low while occupancy is below DEPTH.
- R5: A write strobe while `full` is high and no read is taken is dropped. Stored contents and flags are unchanged.
- R6: A read strobe while `exists` is low is ignored. `exists` stays low, and a later write is read back correctly.
- R7: A read and a write in the same cycle while `full` is high are both taken. `full` stays high, and the new word becomes the last in order.
- R8: A read and a write in the same cycle at partial occupancy leave the occupancy unchanged.
- R9: The tag is kept per word. Adjacent words with tags of 0 and 1 come out each with its own tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe |
| wr_data | input | DW | Word to store |
| wr_tag | input | 1 | Tag for the word (1 marks a control word) |
| full | output | 1 | FIFO holds DEPTH words |
| rd_en | input | 1 | Read strobe, consumes the head word |
| rd_data | output | DW | Head word data |
| rd_tag | output | 1 | Head word tag |
| exists | output | 1 | At least one word is stored |

## Verification
The properties allow the strobes to be asserted freely in any cycle, including writes while `full` is high and reads while `exists` is low. They therefore do not rely on well-behaved masters. They do assume that reset is held for at least one clock edge before any traffic.

The stimulus raises strobes only between clock edges and releases reset after one edge. It deliberately includes strobes that the FIFO must refuse, so that the drop and ignore paths are exercised.

// File: rtl/tsf_pkg.sv
package tsf_pkg;
  // Operation chosen in a cycle from the accepted strobes
  typedef enum logic [1:0] {
    OP_HOLD = 2'b00,
    OP_PUSH = 2'b01,
    OP_POP  = 2'b10,
    OP_SWAP = 2'b11
  } op_e;
endpackage

// File: rtl/tsf_store.sv
module tsf_store #(
  parameter int WW    = 33,
  parameter int DEPTH = 16,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [WW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [WW-1:0] rdata
);
  logic [WW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // fall-through head view
  assign rdata = mem[raddr];
endmodule

// File: rtl/tsf_ctrl.sv
module tsf_ctrl
  import tsf_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          rd_en,
  output logic          push,
  output logic [AW-1:0] wptr,
  output logic [AW-1:0] rptr,
  output logic          full,
  output logic          exists
);
  localparam logic [CW-1:0] CNT_MAX = CW'(DEPTH);
  localparam logic [AW-1:0] PTR_MAX = AW'(DEPTH - 1);

  logic [CW-1:0] cnt, cnt_n;
  logic          pop;
  op_e           op;

  assign pop  = rd_en && exists;
  assign push = wr_en && (!full || pop);
  assign op   = op_e'({pop, push});

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == PTR_MAX) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    unique case (op)
      OP_PUSH: cnt_n = cnt + 1'b1;
      OP_POP:  cnt_n = cnt - 1'b1;
      default: cnt_n = cnt;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      wptr   <= '0;
      rptr   <= '0;
      full   <= 1'b0;
      exists <= 1'b0;
    end else begin
      cnt    <= cnt_n;
      full   <= (cnt_n == CNT_MAX);
      exists <= (cnt_n != '0);
      if (push) wptr <= bump(wptr);
      if (pop)  rptr <= bump(rptr);
    end
  end
endmodule

// File: rtl/tagged_stream_fifo.sv
module tagged_stream_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 16,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int WW   = DW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          wr_tag,
  output logic          full,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          rd_tag,
  output logic          exists
);
  logic          push;
  logic [AW-1:0] wptr, rptr;
  logic [WW-1:0] head;

  tsf_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
    .push(push), .wptr(wptr), .rptr(rptr), .full(full), .exists(exists)
  );

  // tag rides in the top bit of each stored entry
  tsf_store #(.WW(WW), .DEPTH(DEPTH)) u_store (
    .clk(clk), .we(push), .waddr(wptr), .wdata({wr_tag, wr_data}),
    .raddr(rptr), .rdata(head)
  );

  assign rd_tag  = head[WW-1];
  assign rd_data = head[DW-1:0];
endmodule

// File: rtl/tsf_chk.sv
module tsf_chk (
  input logic clk,
  input logic rst,
  input logic wr_en,
  input logic rd_en,
  input logic full,
  input logic exists
);
  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> (!exists && !full));
  // R2
  push_sets_exists_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !full) |=> exists);
  // R4
  full_implies_exists_chk: assert property (@(posedge clk) disable iff (rst)
    full |-> exists);
  // R5
  drop_keeps_full_chk: assert property (@(posedge clk) disable iff (rst)
    (full && !rd_en) |=> full);
  // R6
  empty_read_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (!exists && !wr_en) |=> !exists);
  // R7
  swap_at_full_chk: assert property (@(posedge clk) disable iff (rst)
    (full && rd_en && wr_en) |=> full);
endmodule

bind tagged_stream_fifo tsf_chk u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
  .full(full), .exists(exists)
);

// File: tb/sim_tagged_stream_fifo.sv
module sim_tagged_stream_fifo;
  localparam int DW = 32;
  localparam int D  = 16;

  logic clk = 1'b0;
  logic rst, wr_en, wr_tag, rd_en;
  logic [DW-1:0] wr_data;
  logic full, exists, rd_tag;
  logic [DW-1:0] rd_data;

  int checks = 0;
  int errors = 0;
  logic [DW:0] q[$];

  always #10 clk = ~clk;

  tagged_stream_fifo #(.DW(DW), .DEPTH(D)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .wr_tag(wr_tag),
    .full(full), .rd_en(rd_en), .rd_data(rd_data), .rd_tag(rd_tag), .exists(exists)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // compare flags and head against the expected queue
  task automatic verify(input string req);
    chk(exists == (q.size() != 0), req, "exists", 64'(exists), 64'(q.size() != 0));
    chk(full == (q.size() == D), req, "full", 64'(full), 64'(q.size() == D));
    if (q.size() != 0) begin
      chk(rd_data == q[0][DW-1:0], req, "rd_data", 64'(rd_data), 64'(q[0][DW-1:0]));
      chk(rd_tag == q[0][DW], req, "rd_tag", 64'(rd_tag), 64'(q[0][DW]));
    end
  endtask

  // one cycle of stimulus, driven at negedge; expected state updated from requirements
  task automatic step(input bit w, input logic [DW-1:0] d, input bit t, input bit r,
                      input string req);
    int n;
    bit take_rd, take_wr;
    n = q.size();
    take_rd = r && (n > 0);
    take_wr = w && ((n < D) || take_rd);
    wr_en = w; wr_data = d; wr_tag = t; rd_en = r;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    if (take_rd) void'(q.pop_front());
    if (take_wr) q.push_back({t, d});
    verify(req);
  endtask

  task automatic t_reset();
    rst = 1'b1; wr_en = 0; rd_en = 0; wr_data = '0; wr_tag = 0;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    q.delete();
    chk(!exists, "R1", "exists after reset", 64'(exists), 0);
    chk(!full, "R1", "full after reset", 64'(full), 0);
  endtask

  task automatic t_single();
    step(1, 32'hCAFE_0001, 1'b1, 0, "R2");
    chk(exists, "R2", "exists after write", 64'(exists), 1);
    step(0, '0, 0, 1, "R3");
    chk(!exists, "R3", "empty after read", 64'(exists), 0);
  endtask

  task automatic t_fill_drain();
    for (int i = 0; i < D; i++) begin
      step(1, 32'h1000 + 32'(i), i[0], 0, "R4");
      if (i < D - 1) chk(!full, "R4", "full early", 64'(full), 0);
    end
    chk(full, "R4", "full at depth", 64'(full), 1);
    step(1, 32'hDEAD_DEAD, 1'b1, 0, "R5");
    chk(rd_data == 32'h1000, "R5", "head after drop", 64'(rd_data), 64'h1000);
    for (int i = 0; i < D; i++) step(0, '0, 0, 1, "R9");
    chk(!exists, "R5", "dropped word absent", 64'(exists), 0);
  endtask

  task automatic t_empty_read();
    step(0, '0, 0, 1, "R6");
    chk(!exists, "R6", "exists after empty read", 64'(exists), 0);
    step(1, 32'h0BAD_F00D, 1'b0, 0, "R6");
    chk(rd_data == 32'h0BAD_F00D, "R6", "data after empty read", 64'(rd_data), 64'h0BAD_F00D);
    step(0, '0, 0, 1, "R6");
  endtask

  task automatic t_full_swap();
    for (int i = 0; i < D; i++) step(1, 32'h2000 + 32'(i), ~i[0], 0, "R7");
    step(1, 32'h5555_AAAA, 1'b1, 1, "R7");
    chk(full, "R7", "full after swap", 64'(full), 1);
    for (int i = 0; i < D; i++) step(0, '0, 0, 1, "R7");
  endtask

  task automatic t_mid_swap();
    for (int i = 0; i < 3; i++) step(1, 32'h3000 + 32'(i), i[0], 0, "R8");
    step(1, 32'h3333, 1'b1, 1, "R8");
    step(1, 32'h3334, 1'b0, 1, "R8");
    chk(q.size() == 3, "R8", "occupancy model", 64'(q.size()), 3);
    for (int i = 0; i < 3; i++) step(0, '0, 0, 1, "R8");
    chk(!exists, "R8", "empty after three reads", 64'(exists), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_single();
    t_fill_drain();
    t_empty_read();
    t_full_swap();
    t_mid_swap();
    step(1, 32'h7777, 1'b1, 0, "R1");
    rst = 1'b1; @(negedge clk); rst = 1'b0; q.delete();
    chk(!exists && !full, "R1", "flags after late reset", 64'({exists, full}), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule